// File: doc/BRIEF.md
# SDRAM Command Issue Engine

This block turns a single command word, written by a processor, into the pin-level command sequence an SDRAM expects. It serves up to two chip-select banks. Each command word carries a mode code, one select bit per bank, a repeat count for auto-refresh and a value for the SDRAM mode register. The engine drives the clock-enable, chip-select, row strobe, column strobe, write enable, bank address and address lines. It raises `busy` from the cycle after the write until the last required delay has run out. Software is expected to poll `busy` and wait for it to clear before it writes again. A write that arrives while `busy` is high is dropped and raises `err`.

A single write can start a long burst of commands. For example, it can issue N auto-refreshes, spaced by the row-cycle delay, on one bank or on both banks at the same time. A typical power-up sequence is: enable the clock, wait, precharge all banks, run eight auto-refreshes, load the mode register, then write the normal-mode code.

The controller has three states. `ST_IDLE` drives NOP and waits for a write. `ST_ISSUE` lasts one cycle and puts the decoded command on the pins. `ST_GAP` drives NOP while a down-counter runs off the delay that belongs to the command. The transitions are:
- IDLE→ISSUE on an accepted write.
- ISSUE→GAP always.
- GAP→ISSUE when the counter reaches zero and auto-refresh repeats remain.
- GAP→IDLE when the counter reaches zero and no repeats remain.

Top module: `sdram_cmd_engine`

## Requirements
- R1: After reset the outputs are as follows: `busy` and `err` are 0, `cke` is 00 and `cs_n` is 11. `ras_n`, `cas_n` and `we_n` are 1, and `ba` and `addr` are 0.
- R2: A write of `cmd_word` while `busy` is 0 is accepted. `busy` reads 1 in the next cycle, and the command appears on the pins in that same cycle. Every command on the pins lasts exactly one cycle.
- R3: Bank select works through bit 4 (first bank, `cs_n[0]`) and bit 3 (second bank, `cs_n[1]`). Every bank whose bit is set gets the command. Chip selects hold `~{bit3,bit4}` of the last accepted word, including while idle. If neither bit is set, the timing still runs but no chip select goes low.
- R4: Mode code 2, held in bits [2:0], issues precharge-all. The pins are `ras_n`=0, `cas_n`=1 and `we_n`=0, with `addr[10]`=1, all other address bits 0 and `ba`=0. `busy` lasts t_rp+2 cycles.
- R5: Mode 3 issues auto-refresh with `ras_n`=0, `cas_n`=0 and `we_n`=1. It issues (bits[8:5])+1 refreshes, each starting t_rc+2 cycles after the one before, and `busy` lasts (count+1)·(t_rc+2) cycles.
- R6: Mode 4 loads the mode register. `ras_n`, `cas_n` and `we_n` are all 0, `addr` equals `cmd_word[ADDR_W+8:9]` and `ba`=0. `busy` lasts t_mrd+2 cycles.
- R7: Mode 1 (clock enable) and mode 0 (normal) set `cke` high for the targeted banks from the issue cycle onward. Neither puts a command on the pins, and `busy` lasts 2 cycles.
- R8: Mode 5 (self-refresh entry) issues one refresh with `cke` already low for the targeted banks. Mode 6 (power-down entry) drives NOP with `cke` low for the targeted banks. `cke` stays low afterwards, and `busy` lasts 2 cycles.
- R9: A write while `busy` is 1 is ignored: it adds no command and does not change the `busy` length. `err` reads 1 from the next cycle until the next accepted write, and that write clears it.
- R10: Whenever `busy` is 0, the pins show NOP: `ras_n`, `cas_n` and `we_n` are 1.
- R11: Mode 7 is reserved. It drives NOP, leaves `cke` unchanged and keeps `busy` high for 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_word | input | ADDR_W+9 | Command: mode [2:0], bank selects [4:3], refresh count [8:5], mode value [ADDR_W+8:9] |
| t_rp | input | TW | Row precharge delay in cycles |
| t_rc | input | TW | Row cycle delay in cycles |
| t_mrd | input | TW | Mode-load-to-active delay in cycles |
| busy | output | 1 | Command in progress |
| err | output | 1 | A write was dropped while busy |
| cke | output | 2 | Clock enable per bank |
| cs_n | output | 2 | Chip select per bank, active low |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |

## Verification
The bench targets the following corner cases:
- A multi-refresh burst with a zero row-cycle delay. A counter that is off by one shifts every later refresh, so their cycle stamps fail to match.
- A write injected into the middle of a burst. A design that accepts it emits an extra precharge or stretches `busy`.
- A self-refresh entry, which must show `cke` already low on its refresh cycle. Updating `cke` a cycle late shows up as a mismatched command.
- A command with no bank selected, and a mode load with an all-ones value. A wrong select mapping or a truncated address field gives wrong chip selects or a wrong address.

// File: rtl/sdce_pkg.sv
package sdce_pkg;

    localparam int NBANK       = 2;
    localparam int SEL_B1_BIT  = 4;
    localparam int SEL_B2_BIT  = 3;
    localparam int RPT_LSB     = 5;
    localparam int MRV_LSB     = 9;
    localparam int RPT_W       = MRV_LSB - RPT_LSB;
    localparam int PRE_ALL_BIT = 10;

    typedef enum logic [2:0] {
        MD_NORMAL     = 3'd0,
        MD_CLK_EN     = 3'd1,
        MD_PRECHARGE  = 3'd2,
        MD_AUTOREF    = 3'd3,
        MD_LOAD_MODE  = 3'd4,
        MD_SELF_REF   = 3'd5,
        MD_POWER_DOWN = 3'd6,
        MD_RESERVED   = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        DL_NONE = 2'd0,
        DL_RP   = 2'd1,
        DL_RC   = 2'd2,
        DL_MRD  = 2'd3
    } delay_sel_e;

endpackage

// File: rtl/sdce_cmd_decode.sv
module sdce_cmd_decode
    import sdce_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W+MRV_LSB-1:0] word,
    output mode_e                     mode,
    output logic [NBANK-1:0]          sel,
    output logic [RPT_W-1:0]          reps,
    output logic [ADDR_W-1:0]         mrv,
    output delay_sel_e                dsel
);

    always_comb begin
        mode   = mode_e'(word[2:0]);
        sel[0] = word[SEL_B1_BIT];
        sel[1] = word[SEL_B2_BIT];
        mrv    = word[MRV_LSB +: ADDR_W];
        reps   = '0;
        dsel   = DL_NONE;
        unique case (mode)
            MD_PRECHARGE: dsel = DL_RP;
            MD_AUTOREF: begin
                dsel = DL_RC;
                reps = word[RPT_LSB +: RPT_W];
            end
            MD_LOAD_MODE: dsel = DL_MRD;
            MD_NORMAL, MD_CLK_EN, MD_SELF_REF,
            MD_POWER_DOWN, MD_RESERVED: dsel = DL_NONE;
        endcase
    end

endmodule

// File: rtl/sdce_gap_counter.sv
module sdce_gap_counter #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdce_pin_encode.sv
module sdce_pin_encode
    import sdce_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              issuing,
    input  mode_e             mode,
    input  logic [NBANK-1:0]  sel,
    input  logic [ADDR_W-1:0] mrv,
    input  logic [NBANK-1:0]  cke_held,
    output logic [NBANK-1:0]  cke,
    output logic [NBANK-1:0]  cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr
);

    logic [NBANK-1:0] cke_raise;
    logic [NBANK-1:0] cke_drop;

    always_comb begin
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        we_n      = 1'b1;
        ba        = 2'b00;
        addr      = '0;
        cke_raise = '0;
        cke_drop  = '0;
        if (issuing) begin
            unique case (mode)
                MD_NORMAL, MD_CLK_EN: cke_raise = sel;
                MD_PRECHARGE: begin
                    ras_n             = 1'b0;
                    we_n              = 1'b0;
                    addr[PRE_ALL_BIT] = 1'b1;
                end
                MD_AUTOREF: begin
                    ras_n = 1'b0;
                    cas_n = 1'b0;
                end
                MD_LOAD_MODE: begin
                    ras_n = 1'b0;
                    cas_n = 1'b0;
                    we_n  = 1'b0;
                    addr  = mrv;
                end
                MD_SELF_REF: begin
                    ras_n    = 1'b0;
                    cas_n    = 1'b0;
                    cke_drop = sel;
                end
                MD_POWER_DOWN: cke_drop = sel;
                MD_RESERVED: ;
            endcase
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign cs_n[g] = ~sel[g];
        assign cke[g]  = (cke_held[g] | cke_raise[g]) & ~cke_drop[g];
    end

endmodule

// File: rtl/sdram_cmd_engine.sv
module sdram_cmd_engine
    import sdce_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int TW     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_wr,
    input  logic [ADDR_W+MRV_LSB-1:0] cmd_word,
    input  logic [TW-1:0]             t_rp,
    input  logic [TW-1:0]             t_rc,
    input  logic [TW-1:0]             t_mrd,
    output logic                      busy,
    output logic                      err,
    output logic [NBANK-1:0]          cke,
    output logic [NBANK-1:0]          cs_n,
    output logic                      ras_n,
    output logic                      cas_n,
    output logic                      we_n,
    output logic [1:0]                ba,
    output logic [ADDR_W-1:0]         addr
);

    state_e             state_q, state_d;
    mode_e              dec_mode, mode_q;
    logic [NBANK-1:0]   dec_sel, sel_q;
    logic [RPT_W-1:0]   dec_reps, reps_q;
    logic [ADDR_W-1:0]  dec_mrv, mrv_q;
    delay_sel_e         dec_dsel, dsel_q;
    logic [NBANK-1:0]   cke_q;
    logic               err_q;
    logic               accept;
    logic               gap_zero;
    logic [TW-1:0]      gap_len;

    assign accept = cmd_wr && (state_q == ST_IDLE);

    sdce_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .word (cmd_word),
        .mode (dec_mode),
        .sel  (dec_sel),
        .reps (dec_reps),
        .mrv  (dec_mrv),
        .dsel (dec_dsel)
    );

    always_comb begin
        gap_len = '0;
        unique case (dsel_q)
            DL_NONE: gap_len = '0;
            DL_RP:   gap_len = t_rp;
            DL_RC:   gap_len = t_rc;
            DL_MRD:  gap_len = t_mrd;
        endcase
    end

    sdce_gap_counter #(.TW(TW)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_ISSUE),
        .load_val (gap_len),
        .zero     (gap_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_wr) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_GAP;
            ST_GAP: begin
                if (gap_zero) begin
                    state_d = (reps_q != '0) ? ST_ISSUE : ST_IDLE;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_NORMAL;
            sel_q  <= '0;
            reps_q <= '0;
            mrv_q  <= '0;
            dsel_q <= DL_NONE;
            cke_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                mode_q <= dec_mode;
                sel_q  <= dec_sel;
                reps_q <= dec_reps;
                mrv_q  <= dec_mrv;
                dsel_q <= dec_dsel;
                err_q  <= 1'b0;
            end else if (cmd_wr) begin
                err_q  <= 1'b1;
            end
            if (state_q == ST_GAP && gap_zero && reps_q != '0) begin
                reps_q <= reps_q - 1'b1;
            end
            if (state_q == ST_ISSUE) begin
                cke_q <= cke;
            end
        end
    end

    sdce_pin_encode #(.ADDR_W(ADDR_W)) u_pins (
        .issuing  (state_q == ST_ISSUE),
        .mode     (mode_q),
        .sel      (sel_q),
        .mrv      (mrv_q),
        .cke_held (cke_q),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .addr     (addr)
    );

    assign busy = (state_q != ST_IDLE);
    assign err  = err_q;

endmodule

// File: rtl/sdce_checker.sv
module sdce_checker #(
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_wr,
    input logic [TW-1:0] t_rc,
    input logic          busy,
    input logic          err,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic [1:0]    ba,
    input logic          a10
);

    localparam int SW = TW + 2;

    logic          ref_now;
    logic          seen_q;
    logic [SW-1:0] since_q;

    assign ref_now = !ras_n && !cas_n && we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (ref_now) begin
            seen_q  <= 1'b1;
            since_q <= SW'(1);
        end else begin
            if (!busy) seen_q <= 1'b0;
            if (since_q != {SW{1'b1}}) since_q <= since_q + 1'b1;
        end
    end

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> busy);

    p_cmd_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |=> ras_n);

    p_precharge_a10_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && cas_n && !we_n) |-> (a10 && ba == 2'b00));

    p_ref_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_now && seen_q) |-> (since_q >= SW'(t_rc) + SW'(1)));

    p_load_bank0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n && !we_n) |-> (ba == 2'b00));

    p_busy_write_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> err);

    p_idle_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ras_n && cas_n && we_n));

endmodule

bind sdram_cmd_engine sdce_checker #(.TW(TW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_wr (cmd_wr),
    .t_rc   (t_rc),
    .busy   (busy),
    .err    (err),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .ba     (ba),
    .a10    (addr[10])
);

// File: tb/tb_sdram_cmd_engine.sv
module tb_sdram_cmd_engine;

    localparam int AW = 13;
    localparam int TW = 4;
    localparam int WW = AW + 9;

    typedef struct {
        int          cyc;
        logic [1:0]  cs_n;
        logic [2:0]  rcw;
        logic [1:0]  ba;
        logic [AW-1:0] addr;
        logic [1:0]  cke;
        string       req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [WW-1:0] cmd_word = '0;
    logic [TW-1:0] t_rp = 4'd2, t_rc = 4'd5, t_mrd = 4'd3;
    logic          busy, err, ras_n, cas_n, we_n;
    logic [1:0]    cke, cs_n, ba;
    logic [AW-1:0] addr;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_err = 0;
    item_t exp_q[$];
    item_t mon_it;
    logic [1:0] mcke = 2'b00;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cmd_engine #(.ADDR_W(AW), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .t_rp(t_rp), .t_rc(t_rc), .t_mrd(t_mrd), .busy(busy), .err(err),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] mk(input int mode, input bit b1, input bit b2,
                                         input int rpt, input logic [AW-1:0] mrv);
        return {mrv, 4'(rpt), b1, b2, 3'(mode)};
    endfunction

    // Monitor: pops the scoreboard whenever a selected command is on the pins
    always @(negedge clk) begin
        if (rst_n && cs_n != 2'b11 && !(ras_n && cas_n && we_n)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected command", {cs_n, ras_n, cas_n, we_n}, 0);
            end else begin
                mon_it = exp_q.pop_front();
                check(cyc == mon_it.cyc, mon_it.req, "command cycle", cyc, mon_it.cyc);
                check({cs_n, ras_n, cas_n, we_n, ba, addr, cke} ==
                      {mon_it.cs_n, mon_it.rcw, mon_it.ba, mon_it.addr, mon_it.cke},
                      mon_it.req, "command pins",
                      {cs_n, ras_n, cas_n, we_n, ba, addr, cke},
                      {mon_it.cs_n, mon_it.rcw, mon_it.ba, mon_it.addr, mon_it.cke});
            end
        end
    end

    // Driver: predicts the command stream, writes the word, measures busy
    task automatic run_cmd(input logic [WW-1:0] w, input bit poke, input string req);
        int         mode, d, reps, base, n;
        logic [1:0] tgt;
        logic [2:0] rcw;
        logic [AW-1:0] a;
        item_t      it;
        mode = int'(w[2:0]);
        tgt  = {w[3], w[4]};
        d    = 0;
        reps = 1;
        rcw  = 3'b111;
        a    = '0;
        case (mode)
            0, 1: mcke = mcke | tgt;
            2: begin d = int'(t_rp); rcw = 3'b010; a = 13'h400; end
            3: begin d = int'(t_rc); rcw = 3'b001; reps = int'(w[8:5]) + 1; end
            4: begin d = int'(t_mrd); rcw = 3'b000; a = w[WW-1:9]; end
            5: begin mcke = mcke & ~tgt; rcw = 3'b001; end
            6: mcke = mcke & ~tgt;
            default: ;
        endcase
        @(negedge clk);
        base = cyc;
        if (rcw != 3'b111 && tgt != 2'b00) begin
            for (int k = 0; k < reps; k++) begin
                it.cyc = base + 1 + k * (d + 2);
                it.cs_n = ~tgt; it.rcw = rcw; it.ba = 2'b00;
                it.addr = a; it.cke = mcke; it.req = req;
                exp_q.push_back(it);
            end
        end
        cmd_wr = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(err == 1'b0, "R9", "err after accepted write", err, 0);
        n = 0;
        while (busy) begin
            n++;
            if (poke && n == 2) begin
                cmd_wr = 1'b1;
                cmd_word = mk(2, 1, 1, 0, 0);
            end else begin
                cmd_wr = 1'b0;
            end
            @(negedge clk);
        end
        cmd_wr = 1'b0;
        check(n == reps * (d + 2), req, "busy length", n, reps * (d + 2));
        check(exp_q.size() == 0, req, "missing commands", exp_q.size(), 0);
        check(err == poke, "R9", "err after run", err, poke);
        check(cke == mcke, req, "cke after run", cke, mcke);
        check(cs_n == ~tgt, "R3", "idle chip selects", cs_n, ~tgt);
        check({ras_n, cas_n, we_n} == 3'b111, "R10", "idle NOP", {ras_n, cas_n, we_n}, 7);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({busy, err, cke, cs_n, ras_n, cas_n, we_n, ba, addr} ==
              {1'b0, 1'b0, 2'b00, 2'b11, 3'b111, 2'b00, 13'h0}, "R1", "reset state",
              {busy, err, cke, cs_n, ras_n, cas_n, we_n, ba, addr},
              {1'b0, 1'b0, 2'b00, 2'b11, 3'b111, 2'b00, 13'h0});
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, cs_n, ras_n, cas_n, we_n} == 6'b011111, "R1", "after release",
              {busy, cs_n, ras_n, cas_n, we_n}, 6'b011111);

        run_cmd(mk(1, 1, 0, 0, 0), 0, "R7");          // clock enable, first bank
        run_cmd(mk(2, 1, 1, 0, 0), 0, "R4");          // precharge all, both banks
        run_cmd(mk(3, 1, 0, 7, 0), 0, "R5");          // eight refreshes
        run_cmd(mk(4, 1, 0, 0, 13'h032), 0, "R6");    // load mode register
        run_cmd(mk(0, 1, 1, 0, 0), 0, "R7");          // normal, raises second cke
        t_rc = 4'd0;
        run_cmd(mk(3, 0, 1, 3, 0), 0, "R3");          // second bank only, zero tRC
        t_rc = 4'd2;
        run_cmd(mk(3, 1, 1, 2, 0), 1, "R9");          // write injected mid-burst
        run_cmd(mk(7, 1, 1, 0, 0), 0, "R11");         // reserved code
        run_cmd(mk(5, 0, 1, 0, 0), 0, "R8");          // self-refresh entry
        run_cmd(mk(6, 1, 0, 0, 0), 0, "R8");          // power-down entry
        run_cmd(mk(3, 0, 0, 1, 0), 0, "R3");          // no bank selected
        t_mrd = 4'd0;
        run_cmd(mk(4, 0, 1, 0, 13'h1FFF), 0, "R6");   // all-ones mode value

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule